// File: doc/BRIEF.md
# Inbound Address Translation Window

This block is a single inbound memory window sitting between a host bus and an internal bus. A host address is compared against a programmable base address under a programmable mask. When the address falls inside the window, the block returns the matching internal-bus address. The mask sets the window size in 4 KiB steps. A mask bit of 1 makes the corresponding address bit part of the compare and of the translation. A mask bit of 0 lets that address bit pass through unchanged.

Three registers define the window. The mask (limit) register and the translate register are programmed over the local processor's write path. The base register is programmed from the host side. Every host write to the base register is gated bit by bit by the current mask. As a result, a freshly reset window has an all-zero mask, an all-zero base register that cannot be changed, and it never claims an address. The hit flag and the translated address are combinational functions of the presented address and the registered state.

Top module: `inbound_xlate_window`

## Requirements
- R1: After reset the base, limit and translate registers all read as zero, and `hit` is 0 for any address.
- R2: The limit register changes only on a local write with `lp_sel`=0. Bits 11:0 always read as zero. Host writes at offset 1 have no effect on it.
- R3: A host write at offset 0 loads base bit n (n = 12..31) only where limit bit n is 1. Every other base bit reads as zero, and base bits 11:0 always read zero.
- R4: While the limit is all zeros, host writes to the base register leave it at zero and `hit` stays 0.
- R5: On the clock edge that writes a new limit, every base bit whose new limit bit is 0 is cleared.
- R6: `hit` is 1 exactly when the limit is nonzero and `(in_addr & limit) == (base & limit)`. It is valid in the same cycle the address is presented.
- R7: On a hit, `out_addr` = `(translate & limit) | (in_addr & ~limit)`. On a miss, `out_addr` is zero.
- R8: The translate register changes only on a local write with `lp_sel`=1. Bits 11:0 read as zero. Host writes at offset 2 have no effect on it.
- R9: When a host base write and a local limit write fall on the same edge, the base bits written are masked by the new limit.
- R10: `host_rdata` selects its source combinationally from `host_off`: 0 gives base, 1 gives limit, 2 gives translate, and 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wen | input | 1 | Host write strobe |
| host_off | input | 2 | Host word offset for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_off` |
| lp_wen | input | 1 | Local processor write strobe |
| lp_sel | input | 1 | Local target: 0 limit, 1 translate |
| lp_wdata | input | 32 | Local write data |
| in_addr | input | 32 | Host address to decode |
| hit | output | 1 | Address falls inside the window |
| out_addr | output | 32 | Translated internal address, zero on a miss |

## Verification
The assertions check several invariants on every cycle:
- No base bit is set outside the limit mask.
- The base register holds its value when neither a host write nor a limit change occurs.
- An all-zero limit never produces a hit.
- The limit register moves only on a local write.
- On a hit the page offset passes through, and a miss drives a zero address.

The bench scenarios are what show the actual arithmetic. They check the full compare against the base register, the merged translated address, the offset map of the read port, and the same-edge interplay of a limit write with a host base write. These are compared against a reference model running under random masks and addresses.

// File: rtl/iatw_pkg.sv
package iatw_pkg;
  // Host-side word offsets; the read mux and the base write decode depend on them.
  typedef enum logic [1:0] {
    HOFF_BASE  = 2'd0,
    HOFF_LIMIT = 2'd1,
    HOFF_XLATE = 2'd2,
    HOFF_NONE  = 2'd3
  } host_off_e;

  // Local write target select.
  typedef enum logic {
    LSEL_LIMIT = 1'b0,
    LSEL_XLATE = 1'b1
  } lp_sel_e;
endpackage

// File: rtl/iatw_rst_sync.sv
module iatw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/iatw_local_regs.sv
module iatw_local_regs #(
  parameter int unsigned HI_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lp_wen,
  input  logic            lp_sel,
  input  logic [HI_W-1:0] lp_wdata_hi,
  output logic [HI_W-1:0] lim_q,
  output logic [HI_W-1:0] lim_d,
  output logic [HI_W-1:0] xl_q
);
  import iatw_pkg::*;

  logic            lim_en;
  logic            xl_en;
  logic [HI_W-1:0] xl_d;

  always_comb begin
    lim_en = lp_wen && (lp_sel == LSEL_LIMIT);
    xl_en  = lp_wen && (lp_sel == LSEL_XLATE);
    lim_d  = lim_en ? lp_wdata_hi : lim_q;
    xl_d   = lp_wdata_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
    end else begin
      lim_q <= lim_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_q <= '0;
    end else if (xl_en) begin
      xl_q <= xl_d;
    end
  end

  // R2: the limit only moves on a local limit write
  assert_limit_local_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_wen && lp_sel == LSEL_LIMIT) |=> $stable(lim_q));

  // R8: the translate value only moves on a local translate write
  assert_xlate_local_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_wen && lp_sel == LSEL_XLATE) |=> $stable(xl_q));
endmodule

// File: rtl/iatw_base_reg.sv
module iatw_base_reg #(
  parameter int unsigned HI_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wen,
  input  logic [HI_W-1:0] wdata_hi,
  input  logic [HI_W-1:0] lim_d,
  input  logic [HI_W-1:0] lim_q,
  output logic [HI_W-1:0] base_q
);
  logic [HI_W-1:0] base_d;

  // Each bit is gated by the limit value that will hold after this edge,
  // so a limit rewrite clears newly masked bits on the same edge.
  for (genvar i = 0; i < HI_W; i++) begin : g_bit
    always_comb begin
      base_d[i] = lim_d[i] & (wen ? wdata_hi[i] : base_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else begin
      base_q <= base_d;
    end
  end

  // R3: no base bit survives outside the mask
  assert_masked_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q & ~lim_q) == '0);

  // R3: without a write or a limit change the base holds
  assert_base_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wen && lim_d == lim_q) |=> $stable(base_q));

  // R4: a host write under an all-zero limit leaves the base at zero
  assert_zero_limit_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && lim_d == '0) |=> base_q == '0);

  // R5: a limit rewrite leaves nothing outside the new mask
  assert_rewrite_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_d != lim_q) |=> (base_q & ~lim_q) == '0);
endmodule

// File: rtl/iatw_decode.sv
module iatw_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LOW_W  = 12,
  localparam int unsigned HI_W  = ADDR_W - LOW_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HI_W-1:0]   lim_q,
  input  logic [HI_W-1:0]   base_q,
  input  logic [HI_W-1:0]   xl_q,
  output logic              hit,
  output logic [ADDR_W-1:0] out_addr
);
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] base_full;
  logic [ADDR_W-1:0] xl_full;
  logic              tag_eq;

  always_comb begin
    mask      = {lim_q,  {LOW_W{1'b0}}};
    base_full = {base_q, {LOW_W{1'b0}}};
    xl_full   = {xl_q,   {LOW_W{1'b0}}};
    tag_eq    = ((addr ^ base_full) & mask) == '0;
    hit       = (|lim_q) && tag_eq;
    out_addr  = hit ? ((xl_full & mask) | (addr & ~mask)) : '0;
  end
endmodule

// File: rtl/inbound_xlate_window.sv
module inbound_xlate_window #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LOW_W     = 12,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wen,
  input  logic [1:0]        host_off,
  input  logic [ADDR_W-1:0] host_wdata,
  output logic [ADDR_W-1:0] host_rdata,
  input  logic              lp_wen,
  input  logic              lp_sel,
  input  logic [ADDR_W-1:0] lp_wdata,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] out_addr
);
  import iatw_pkg::*;

  localparam int unsigned HI_W = ADDR_W - LOW_W;

  logic            rst_sync_n;
  logic [HI_W-1:0] lim_q;
  logic [HI_W-1:0] lim_d;
  logic [HI_W-1:0] xl_q;
  logic [HI_W-1:0] base_q;
  logic            base_wen;
  host_off_e       off;

  iatw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  iatw_local_regs #(.HI_W(HI_W)) u_local (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .lp_wen      (lp_wen),
    .lp_sel      (lp_sel),
    .lp_wdata_hi (lp_wdata[ADDR_W-1:LOW_W]),
    .lim_q       (lim_q),
    .lim_d       (lim_d),
    .xl_q        (xl_q)
  );

  always_comb begin
    off      = host_off_e'(host_off);
    base_wen = host_wen && (off == HOFF_BASE);
  end

  iatw_base_reg #(.HI_W(HI_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wen      (base_wen),
    .wdata_hi (host_wdata[ADDR_W-1:LOW_W]),
    .lim_d    (lim_d),
    .lim_q    (lim_q),
    .base_q   (base_q)
  );

  iatw_decode #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_dec (
    .addr     (in_addr),
    .lim_q    (lim_q),
    .base_q   (base_q),
    .xl_q     (xl_q),
    .hit      (hit),
    .out_addr (out_addr)
  );

  always_comb begin
    unique case (off)
      HOFF_BASE:  host_rdata = {base_q, {LOW_W{1'b0}}};
      HOFF_LIMIT: host_rdata = {lim_q,  {LOW_W{1'b0}}};
      HOFF_XLATE: host_rdata = {xl_q,   {LOW_W{1'b0}}};
      default:    host_rdata = '0;
    endcase
  end

  // R4: an empty mask never claims an address
  assert_no_hit_empty_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lim_q == '0) |-> !hit);

  // R7: the page offset passes straight through on a hit
  assert_offset_pass_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |-> out_addr[LOW_W-1:0] == in_addr[LOW_W-1:0]);

  // R7: a miss drives a zero address
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |-> out_addr == '0);

  // R10: the reserved offset reads zero
  assert_spare_off_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_off == 2'd3) |-> host_rdata == '0);
endmodule

// File: tb/inbound_xlate_window_test.sv
module inbound_xlate_window_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wen;
  logic [1:0]  host_off;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        lp_wen;
  logic        lp_sel;
  logic [31:0] lp_wdata;
  logic [31:0] in_addr;
  logic        hit;
  logic [31:0] out_addr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] m_lim, m_base, m_xl;

  always #4 clk = ~clk;

  inbound_xlate_window uut (
    .clk(clk), .rst_n(rst_n), .host_wen(host_wen), .host_off(host_off),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .lp_wen(lp_wen),
    .lp_sel(lp_sel), .lp_wdata(lp_wdata), .in_addr(in_addr), .hit(hit),
    .out_addr(out_addr)
  );

  function automatic logic exp_hit(input logic [31:0] a);
    return (m_lim != 0) && ((a & m_lim) == (m_base & m_lim));
  endfunction

  function automatic logic [31:0] exp_out(input logic [31:0] a);
    return exp_hit(a) ? ((m_xl & m_lim) | (a & ~m_lim)) : 32'h0;
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // One clock with the given strobes, then the model follows the requirements.
  task automatic step(input logic hw, input logic [1:0] ho, input logic [31:0] hd,
                      input logic lw, input logic ls, input logic [31:0] ld);
    logic [31:0] nl;
    @(negedge clk);
    host_wen = hw; host_off = ho; host_wdata = hd;
    lp_wen = lw; lp_sel = ls; lp_wdata = ld;
    @(posedge clk);
    nl = (lw && !ls) ? (ld & 32'hFFFF_F000) : m_lim;          // R2
    m_base = ((hw && ho == 2'd0) ? hd : m_base) & nl;          // R3 R5 R9
    if (lw && ls) m_xl = ld & 32'hFFFF_F000;                   // R8
    m_lim = nl;
    #1;
    host_wen = 1'b0; lp_wen = 1'b0;
  endtask

  task automatic check_regs(input string req);
    @(negedge clk);
    host_off = 2'd0; #1; check32({req, " base"}, host_rdata, m_base);
    host_off = 2'd1; #1; check32({req, " limit"}, host_rdata, m_lim);
    host_off = 2'd2; #1; check32({req, " xlate"}, host_rdata, m_xl);
    host_off = 2'd3; #1; check32("R10 spare", host_rdata, 32'h0);
  endtask

  task automatic check_lookup(input string req, input logic [31:0] a);
    @(negedge clk);
    in_addr = a; #1;
    check32({req, " hit"}, {31'h0, hit}, {31'h0, exp_hit(a)});
    check32({req, " out"}, out_addr, exp_out(a));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1'b1;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lim_v;
    void'($urandom(32'd2024));
    rst_n = 1'b0; host_wen = 0; host_off = 0; host_wdata = 0;
    lp_wen = 0; lp_sel = 0; lp_wdata = 0; in_addr = 0;
    m_lim = 0; m_base = 0; m_xl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    check_regs("R1");
    check_lookup("R1", 32'h0000_0000);
    check_lookup("R1", 32'hDEAD_B000);

    // R4 writes under a zero limit have no effect
    step(1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0);
    check_regs("R4");
    check_lookup("R4", 32'h0000_0123);

    // R2 host write at the limit offset is ignored, R8 likewise for translate
    step(1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0);
    step(1, 2'd2, 32'hFFFF_FFFF, 0, 0, 0);
    check_regs("R2 R8 host");

    // R2 local limit write, low bits read zero; R8 translate write
    step(0, 0, 0, 1, 0, 32'hFFFF_0FFF);
    step(0, 0, 0, 1, 1, 32'h8765_4ABC);
    check_regs("R2 R8 local");

    // R3 base write masked by limit
    step(1, 2'd0, 32'h1234_5678, 0, 0, 0);
    check_regs("R3");
    check_lookup("R6", 32'h1234_0ABC);
    check_lookup("R7", 32'h1234_0FFF);
    check_lookup("R6 miss", 32'h1235_0000);

    // R5 shrinking the limit clears masked base bits on the same edge
    step(0, 0, 0, 1, 0, 32'hFF00_0000);
    check_regs("R5");
    check_lookup("R7", 32'h12AB_CDEF);

    // R9 same-edge base write and limit write
    step(1, 2'd0, 32'hFFFF_FFFF, 1, 0, 32'hF0F0_0000);
    check_regs("R9");

    // R4 back to zero limit disables window
    step(0, 0, 0, 1, 0, 32'h0);
    check_regs("R4 clear");
    check_lookup("R4", 32'h0000_0000);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int kind = $urandom_range(0, 5);
      case (kind)
        0: begin
          lim_v = 32'hFFFF_FFFF << $urandom_range(12, 32 - 1);
          if ($urandom_range(0, 3) == 0) lim_v = $urandom;
          step(0, 0, 0, 1, 0, lim_v);
        end
        1: step(0, 0, 0, 1, 1, $urandom);
        2: step(1, 2'($urandom_range(0, 3)), $urandom, 0, 0, 0);
        3: step(1, 2'd0, $urandom, 1, 0, $urandom);
        default: step(1, 2'd0, $urandom, 0, 0, 0);
      endcase
      if (i % 4 == 0) check_regs("R3 R10 rand");
      check_lookup("R6 R7 rand", (m_base & m_lim) | ($urandom & ~m_lim));
      check_lookup("R6 R7 rand", $urandom);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule